// File: doc/BRIEF.md
# Panel Sync Timing Generator

This block produces the scan timing for a parallel display panel. It holds a horizontal position counter and a vertical line counter. From them it derives horizontal and vertical sync pulses, a data-enable window that frames the visible pixels, and an AC-bias output that inverts its level once per programmed number of lines. It also raises single-cycle frame-start and frame-end strobes for an interrupt unit. Software places every edge through start/end position pairs, so the same hardware serves layouts with the syncs ahead of the picture and layouts with a trailing line sync.

Each position input is a pair word. The start position sits in the upper half and the end position in the lower half. A window or pulse is active while start <= count < end. The area word gives the line length in its upper half and the number of lines per frame in its lower half. The layout-mode input selects parallel TFT timing, serial TFT timing with three clocks per pixel position, or STN timing, in which the line sync width and the porch after it are padded to the width of the data bus. All inputs are captured together, so a frame is never drawn with a mix of old and new settings.

Top module: `panel_sync_timing`

## Requirements
- R1: While rst_n is low (synchronous, active low), hcount and vcount are 0, ac_bias is 0 and frame_end is 0, and all configuration inputs are captured into the working settings.
- R2: hcount steps 0,1,...,L-1 and wraps to 0, where L is the upper half of area_size. vcount advances by one on each wrap of hcount and runs 0,...,N-1, where N is the lower half of area_size.
- R3: hsync is high while S <= hcount < E, with S the upper half and E the lower half of hsync_pos. vsync is decoded from vsync_pos against vcount in the same way.
- R4: de is high exactly when hcount lies in the hvis_pos span and vcount lies in the vvis_pos span (same start/end encoding as R3).
- R5: frame_start is high for one cycle, the first clock in which hcount and vcount equal the start of the horizontal and vertical visible spans.
- R6: frame_end is high for one cycle, the cycle after the last clock of the last visible pixel (hcount = horizontal end - 1, vcount = vertical end - 1).
- R7: At the end of every line a bias line counter advances. When its incremented value reaches or passes the lower half of bias_pos, it reloads the upper half of bias_pos and ac_bias inverts. ac_bias changes at no other time.
- R8: Changes on the configuration inputs during a frame have no effect until the first cycle of the next frame.
- R9: layout_mode 2'b01 (serial TFT) holds each hcount value for three clocks. 2'b00 and 2'b11 (parallel TFT) and 2'b10 (STN) hold it for one clock.
- R10: With layout_mode 2'b10, and P = 2^stn_pins_log2, the hsync width (end - start) and the porch from hsync end to the line length are each rounded up to a multiple of P. The hsync end and the line length are recomputed from those rounded widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| layout_mode | input | 2 | 00/11 parallel TFT, 01 serial TFT, 10 STN |
| stn_pins_log2 | input | 2 | log2 of STN data bus width |
| hsync_pos | input | 2*CW | Line sync start (upper) / end (lower) |
| vsync_pos | input | 2*CW | Frame sync start / end in lines |
| area_size | input | 2*CW | Line length (upper) / lines per frame (lower) |
| hvis_pos | input | 2*CW | Visible pixel start / end |
| vvis_pos | input | 2*CW | Visible line start / end |
| bias_pos | input | 2*CW | Bias reload value / toggle threshold in lines |
| hcount | output | CW | Horizontal position |
| vcount | output | CW | Line number |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data-enable window |
| ac_bias | output | 1 | AC-bias level |
| frame_start | output | 1 | Strobe at first visible pixel |
| frame_end | output | 1 | Strobe after last visible pixel |

## Verification
The frame-end strobe and the settings reload can land in the same cycle. This happens when the visible window ends at the final position of the frame: the strobe then appears in the first cycle of the next frame, while the next frame's settings already drive the counters and windows. The bench provokes this with a frame whose visible spans run up to both totals. A mid-frame settings change is queued for the next frame, which uses a different layout. The scoreboard expects the strobe to come from the old window and every other output to follow the new settings. The AC-bias inversion falls on that same boundary edge and is judged against the old threshold.

// File: rtl/pst_pkg.sv
// Shared definitions for the panel sync timing generator.
// Assumes: layout code 2'b11 is treated as parallel TFT.
package pst_pkg;
    typedef enum logic [1:0] {
        LAYOUT_TFT        = 2'b00,
        LAYOUT_TFT_SERIAL = 2'b01,
        LAYOUT_STN        = 2'b10,
        LAYOUT_TFT_ALT    = 2'b11
    } layout_e;

    // Clocks spent on each position in serial TFT mode.
    localparam int SERIAL_CLKS = 3;
endpackage

// File: rtl/pst_shadow_regs.sv
// Working copy of the timing settings.
// Captures every position pair during reset and on the frame wrap, so a
// frame always runs on one consistent set. In STN layout the line sync
// width and trailing porch are padded to the bus width here.
// Assumes: hsync end >= start and line length >= hsync end.
module pst_shadow_regs
    import pst_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [1:0]      mode,
    input  logic [1:0]      pins_log2,
    input  logic [2*CW-1:0] hs_pair,
    input  logic [2*CW-1:0] vs_pair,
    input  logic [2*CW-1:0] area_pair,
    input  logic [2*CW-1:0] hv_pair,
    input  logic [2*CW-1:0] vv_pair,
    input  logic [2*CW-1:0] bias_pair,
    output logic            serial,
    output logic [CW-1:0]   hs_s,
    output logic [CW-1:0]   hs_e,
    output logic [CW-1:0]   vs_s,
    output logic [CW-1:0]   vs_e,
    output logic [CW-1:0]   htot,
    output logic [CW-1:0]   vtot,
    output logic [CW-1:0]   hv_s,
    output logic [CW-1:0]   hv_e,
    output logic [CW-1:0]   vv_s,
    output logic [CW-1:0]   vv_e,
    output logic [CW-1:0]   b_s,
    output logic [CW-1:0]   b_e
);
    // Round x up to a multiple of (m + 1), m being a low-bit mask.
    function automatic logic [CW-1:0] pad_up(input logic [CW-1:0] x,
                                             input logic [CW-1:0] m);
        return (x + m) & ~m;
    endfunction

    logic [CW-1:0] pin_mask;
    logic          is_stn;
    logic [CW-1:0] raw_hs_s, raw_hs_e, raw_htot;
    logic [CW-1:0] nxt_hs_e, nxt_htot;

    assign raw_hs_s = hs_pair[2*CW-1:CW];
    assign raw_hs_e = hs_pair[CW-1:0];
    assign raw_htot = area_pair[2*CW-1:CW];
    assign is_stn   = (mode == LAYOUT_STN);
    assign pin_mask = CW'((32'd1 << pins_log2) - 32'd1);

    // Derive the effective line sync end and line length for the layout.
    always_comb begin
        if (is_stn) begin
            nxt_hs_e = raw_hs_s + pad_up(raw_hs_e - raw_hs_s, pin_mask);
            nxt_htot = nxt_hs_e + pad_up(raw_htot - raw_hs_e, pin_mask);
        end else begin
            nxt_hs_e = raw_hs_e;
            nxt_htot = raw_htot;
        end
    end

    // Capture all settings together in reset or at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            serial <= (mode == LAYOUT_TFT_SERIAL);
            hs_s   <= raw_hs_s;
            hs_e   <= nxt_hs_e;
            htot   <= nxt_htot;
            vs_s   <= vs_pair[2*CW-1:CW];
            vs_e   <= vs_pair[CW-1:0];
            vtot   <= area_pair[CW-1:0];
            hv_s   <= hv_pair[2*CW-1:CW];
            hv_e   <= hv_pair[CW-1:0];
            vv_s   <= vv_pair[2*CW-1:CW];
            vv_e   <= vv_pair[CW-1:0];
            b_s    <= bias_pair[2*CW-1:CW];
            b_e    <= bias_pair[CW-1:0];
        end
    end

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({serial, hs_s, hs_e, htot, vs_s, vs_e, vtot,
                           hv_s, hv_e, vv_s, vv_e, b_s, b_e}));
endmodule

// File: rtl/pst_scan_counters.sv
// Horizontal position and line counters with the serial sub-pixel phase.
// A position advances on each pixel tick. In serial mode a tick comes every
// third clock. The line counter advances when the position wraps.
// Assumes: totals are loaded only at the frame wrap, when both counters are 0.
module pst_scan_counters
    import pst_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          serial,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vtot,
    output logic [CW-1:0] h,
    output logic [CW-1:0] v,
    output logic          tick,
    output logic          first_clk,
    output logic          line_end,
    output logic          frame_wrap
);
    localparam logic [1:0] SUB_LAST = 2'(SERIAL_CLKS - 1);

    logic [1:0]    sub_q;
    logic [CW-1:0] h_q, v_q;
    logic          h_last, v_last;

    assign tick       = serial ? (sub_q == SUB_LAST) : 1'b1;
    assign first_clk  = (sub_q == 2'd0);
    assign h_last     = ({1'b0, h_q} + (CW+1)'(1)) >= {1'b0, htot};
    assign v_last     = ({1'b0, v_q} + (CW+1)'(1)) >= {1'b0, vtot};
    assign line_end   = tick && h_last;
    assign frame_wrap = line_end && v_last;
    assign h          = h_q;
    assign v          = v_q;

    // Sub-pixel phase: cycles through three clocks only in serial mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !serial || sub_q == SUB_LAST)
            sub_q <= 2'd0;
        else
            sub_q <= sub_q + 2'd1;
    end

    // Position and line counters, wrapping at their totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (tick) begin
            if (h_last) begin
                h_q <= '0;
                v_q <= v_last ? '0 : v_q + CW'(1);
            end else begin
                h_q <= h_q + CW'(1);
            end
        end
    end

    // R2
    hcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htot != '0) |-> (h_q < htot));

    // R9
    serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serial && sub_q != SUB_LAST) |=> $stable(h_q));
endmodule

// File: rtl/pst_ac_bias.sv
// AC-bias generator: counts lines and inverts its output each time the
// count reaches the programmed threshold, then reloads the start value.
// Assumes: line_end is a single-cycle strobe per line.
module pst_ac_bias #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [CW-1:0] b_s,
    input  logic [CW-1:0] b_e,
    output logic          ac_bias
);
    logic [CW-1:0] bcnt_q;
    logic          bias_q;
    logic          reach;

    assign reach   = ({1'b0, bcnt_q} + (CW+1)'(1)) >= {1'b0, b_e};
    assign ac_bias = bias_q;

    // Line count and bias level, updated once per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt_q <= '0;
            bias_q <= 1'b0;
        end else if (line_end) begin
            if (reach) begin
                bcnt_q <= b_s;
                bias_q <= ~bias_q;
            end else begin
                bcnt_q <= bcnt_q + CW'(1);
            end
        end
    end

    // R7
    bias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(bias_q));
endmodule

// File: rtl/panel_sync_timing.sv
// Top of the panel sync timing generator.
// Ties the settings copy, scan counters and bias generator together. It
// decodes the sync and visible spans and forms the frame strobes.
// Assumes: outputs feed registered logic; spans decode combinationally.
module panel_sync_timing #(
    parameter int CW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      layout_mode,
    input  logic [1:0]      stn_pins_log2,
    input  logic [2*CW-1:0] hsync_pos,
    input  logic [2*CW-1:0] vsync_pos,
    input  logic [2*CW-1:0] area_size,
    input  logic [2*CW-1:0] hvis_pos,
    input  logic [2*CW-1:0] vvis_pos,
    input  logic [2*CW-1:0] bias_pos,
    output logic [CW-1:0]   hcount,
    output logic [CW-1:0]   vcount,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic            ac_bias,
    output logic            frame_start,
    output logic            frame_end
);
    localparam int NSPAN = 4;

    logic          serial, tick, first_clk, line_end, frame_wrap;
    logic [CW-1:0] hs_s, hs_e, vs_s, vs_e, htot, vtot;
    logic [CW-1:0] hv_s, hv_e, vv_s, vv_e, b_s, b_e;
    logic [CW-1:0] h, v;
    logic          fe_q;

    pst_shadow_regs #(.CW(CW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(frame_wrap),
        .mode(layout_mode), .pins_log2(stn_pins_log2),
        .hs_pair(hsync_pos), .vs_pair(vsync_pos), .area_pair(area_size),
        .hv_pair(hvis_pos), .vv_pair(vvis_pos), .bias_pair(bias_pos),
        .serial(serial), .hs_s(hs_s), .hs_e(hs_e), .vs_s(vs_s), .vs_e(vs_e),
        .htot(htot), .vtot(vtot), .hv_s(hv_s), .hv_e(hv_e),
        .vv_s(vv_s), .vv_e(vv_e), .b_s(b_s), .b_e(b_e)
    );

    pst_scan_counters #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .serial(serial), .htot(htot), .vtot(vtot),
        .h(h), .v(v), .tick(tick), .first_clk(first_clk),
        .line_end(line_end), .frame_wrap(frame_wrap)
    );

    pst_ac_bias #(.CW(CW)) u_bias (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .b_s(b_s), .b_e(b_e), .ac_bias(ac_bias)
    );

    // Span decoders: 0 hsync, 1 vsync, 2 horizontal visible, 3 vertical visible.
    logic [CW-1:0]    sp_cnt [NSPAN];
    logic [CW-1:0]    sp_lo  [NSPAN];
    logic [CW-1:0]    sp_hi  [NSPAN];
    logic [NSPAN-1:0] sp_in;

    assign sp_cnt[0] = h;  assign sp_lo[0] = hs_s;  assign sp_hi[0] = hs_e;
    assign sp_cnt[1] = v;  assign sp_lo[1] = vs_s;  assign sp_hi[1] = vs_e;
    assign sp_cnt[2] = h;  assign sp_lo[2] = hv_s;  assign sp_hi[2] = hv_e;
    assign sp_cnt[3] = v;  assign sp_lo[3] = vv_s;  assign sp_hi[3] = vv_e;

    generate
        for (genvar i = 0; i < NSPAN; i++) begin : g_span
            assign sp_in[i] = (sp_cnt[i] >= sp_lo[i]) && (sp_cnt[i] < sp_hi[i]);
        end
    endgenerate

    assign hcount      = h;
    assign vcount      = v;
    assign hsync       = sp_in[0];
    assign vsync       = sp_in[1];
    assign de          = sp_in[2] && sp_in[3];
    assign frame_start = de && first_clk && (h == hv_s) && (v == vv_s);
    assign frame_end   = fe_q;

    // Frame-end strobe: registered from the last clock of the last visible pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fe_q <= 1'b0;
        else
            fe_q <= de && tick && (h == hv_e - CW'(1)) && (v == vv_e - CW'(1));
    end

    // R5
    fstart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && htot > CW'(1)) |=> !frame_start);

    // R6
    fend_after_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> $past(de));
endmodule

// File: tb/tb_panel_sync_timing.sv
`timescale 1ns/1ps
module tb_panel_sync_timing;
    localparam int CW = 11;

    typedef struct {
        int mode, pl;
        int hss, hse, vss, vse, htot, vtot, hvs, hve, vvs, vve, bs, be;
    } cfg_t;

    typedef struct {
        int    h, v;
        bit    hs, vs, de, fs, fe, bias;
        string tag;
        int    mode;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      layout_mode = '0;
    logic [1:0]      stn_pins_log2 = '0;
    logic [2*CW-1:0] hsync_pos = '0, vsync_pos = '0, area_size = '0;
    logic [2*CW-1:0] hvis_pos = '0, vvis_pos = '0, bias_pos = '0;
    logic [CW-1:0]   hcount, vcount;
    logic            hsync, vsync, de, ac_bias, frame_start, frame_end;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   armed = 0;
    bit   done = 0;
    exp_t q[$];

    // generator state carried between frames
    int bcnt = 0;
    bit bias_m = 0;
    bit prev_fe = 0;

    always #2.5 clk = ~clk;

    panel_sync_timing #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .layout_mode(layout_mode),
        .stn_pins_log2(stn_pins_log2), .hsync_pos(hsync_pos),
        .vsync_pos(vsync_pos), .area_size(area_size), .hvis_pos(hvis_pos),
        .vvis_pos(vvis_pos), .bias_pos(bias_pos), .hcount(hcount),
        .vcount(vcount), .hsync(hsync), .vsync(vsync), .de(de),
        .ac_bias(ac_bias), .frame_start(frame_start), .frame_end(frame_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input cfg_t c);
        layout_mode   = 2'(c.mode);
        stn_pins_log2 = 2'(c.pl);
        hsync_pos = {CW'(c.hss), CW'(c.hse)};
        vsync_pos = {CW'(c.vss), CW'(c.vse)};
        area_size = {CW'(c.htot), CW'(c.vtot)};
        hvis_pos  = {CW'(c.hvs), CW'(c.hve)};
        vvis_pos  = {CW'(c.vvs), CW'(c.vve)};
        bias_pos  = {CW'(c.bs), CW'(c.be)};
    endtask

    // Effective line sync end and line length per R10.
    function automatic void eff_h(input cfg_t c, output int hse, output int ht);
        int m;
        if (c.mode == 2) begin
            m   = (1 << c.pl) - 1;
            hse = c.hss + ((c.hse - c.hss + m) & ~m);
            ht  = hse + ((c.htot - c.hse + m) & ~m);
        end else begin
            hse = c.hse;
            ht  = c.htot;
        end
    endfunction

    function automatic int frame_len(input cfg_t c);
        int hse, ht;
        eff_h(c, hse, ht);
        return ht * c.vtot * ((c.mode == 1) ? 3 : 1);
    endfunction

    // Driver: push one frame of expected outputs into the scoreboard.
    task automatic gen_frame(input cfg_t c, input string tag);
        int hse, ht, reps;
        exp_t e;
        eff_h(c, hse, ht);
        reps = (c.mode == 1) ? 3 : 1;
        for (int v = 0; v < c.vtot; v++)
            for (int h = 0; h < ht; h++)
                for (int s = 0; s < reps; s++) begin
                    e.h    = h;
                    e.v    = v;
                    e.hs   = (h >= c.hss) && (h < hse);
                    e.vs   = (v >= c.vss) && (v < c.vse);
                    e.de   = (h >= c.hvs) && (h < c.hve) && (v >= c.vvs) && (v < c.vve);
                    e.fs   = e.de && (h == c.hvs) && (v == c.vvs) && (s == 0);
                    e.fe   = prev_fe;
                    e.bias = bias_m;
                    e.tag  = tag;
                    e.mode = c.mode;
                    q.push_back(e);
                    prev_fe = e.de && (h == c.hve - 1) && (v == c.vve - 1) && (s == reps - 1);
                    if (s == reps - 1 && h == ht - 1) begin
                        if (bcnt + 1 >= c.be) begin
                            bcnt   = c.bs;
                            bias_m = !bias_m;
                        end else begin
                            bcnt = bcnt + 1;
                        end
                    end
                end
    endtask

    // Monitor: pop and compare one expected item per clock.
    initial begin
        exp_t e;
        string hreq;
        forever begin
            @(negedge clk);
            #1;
            if (armed && q.size() > 0) begin
                e = q.pop_front();
                hreq = (e.mode == 1) ? "R9" : (e.mode == 2) ? "R10" : "R2";
                chk({hreq, " hcount/", e.tag}, int'(hcount), e.h);
                chk({"R2 vcount/", e.tag}, int'(vcount), e.v);
                chk({(e.mode == 2) ? "R10" : "R3", " hsync/", e.tag}, int'(hsync), int'(e.hs));
                chk({"R3 vsync/", e.tag}, int'(vsync), int'(e.vs));
                chk({"R4 de/", e.tag}, int'(de), int'(e.de));
                chk({"R5 frame_start/", e.tag}, int'(frame_start), int'(e.fs));
                chk({"R6 frame_end/", e.tag}, int'(frame_end), int'(e.fe));
                chk({"R7 ac_bias/", e.tag}, int'(ac_bias), int'(e.bias));
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_t  cf[7];
        string tg[7];
        int    start[7];
        int    cur, target;
        // A: parallel TFT, syncs ahead of the picture
        cf[0] = '{mode:0, pl:0, hss:0, hse:2, vss:0, vse:1, htot:10, vtot:6,
                  hvs:3, hve:8, vvs:2, vve:5, bs:0, be:6};
        cf[1] = cf[0];
        // B: visible spans reach both totals (frame_end lands on the wrap)
        cf[2] = '{mode:3, pl:0, hss:0, hse:1, vss:0, vse:2, htot:9, vtot:5,
                  hvs:2, hve:9, vvs:3, vve:5, bs:0, be:5};
        // C: STN, four data pins, trailing line sync
        cf[3] = '{mode:2, pl:2, hss:7, hse:9, vss:0, vse:1, htot:12, vtot:6,
                  hvs:2, hve:7, vvs:0, vve:4, bs:0, be:6};
        cf[4] = cf[3];
        // D: serial TFT
        cf[5] = '{mode:1, pl:0, hss:0, hse:1, vss:0, vse:1, htot:6, vtot:4,
                  hvs:2, hve:5, vvs:1, vve:3, bs:0, be:4};
        cf[6] = cf[0];
        tg[0] = "R1"; tg[1] = "R2"; tg[2] = "R8"; tg[3] = "R10";
        tg[4] = "R10"; tg[5] = "R9"; tg[6] = "R8";
        start[0] = 0;
        for (int f = 1; f < 7; f++) start[f] = start[f-1] + frame_len(cf[f-1]);

        drive(cf[0]);
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 hcount", int'(hcount), 0);
        chk("R1 vcount", int'(vcount), 0);
        chk("R1 ac_bias", int'(ac_bias), 0);
        chk("R1 frame_end", int'(frame_end), 0);
        chk("R1 de", int'(de), 0);

        for (int f = 0; f < 7; f++) gen_frame(cf[f], tg[f]);

        @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;
        cur = 0;
        // R8: settings change mid-frame, expected to apply from the next frame
        for (int f = 1; f < 7; f++) begin
            if (cf[f] != cf[f-1]) begin
                target = start[f-1] + 5;
                repeat (target - cur) @(negedge clk);
                drive(cf[f]);
                cur = target;
            end
        end
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule